// File: doc/BRIEF.md
# Cascaded Edge-Triggered Interrupt Controller

This block gathers sixteen edge-triggered interrupt lines into a single interrupt request for a processor. It holds two identical 8-line controller units. The upper unit, the secondary, has its interrupt output wired into one input of the primary unit. Software programs each unit over a byte-wide register port that has one address bit. A write to the even address with bit 4 set starts a short initialization sequence. The later words of that sequence, written to the odd address, set the vector base, the cascade wiring and the operating mode. After initialization, the odd address holds the per-line mask and the even address accepts end-of-interrupt commands.

When `int_out` is high, the processor pulses `inta`. In the next cycle the block presents an 8-bit vector equal to the base of the owning unit plus the line index. The acknowledged request moves into service, and it blocks that line and every lower-priority line until software writes an end-of-interrupt command. A line behind the secondary needs that command in both units. With base words 0x20 and 0x28 and the secondary on primary line 2, the sixteen lines map to vectors 0x20 through 0x2F.

Each unit has its own initialization state machine with five states:
- `ST_UNINIT` is the reset state.
- `ST_BASE` waits for the base word.
- `ST_CASC` waits for the cascade word.
- `ST_MODE` waits for the mode word.
- `ST_RUN` is normal operation.

The transitions are:
- start: any state goes to `ST_BASE` on the start write.
- base-to-cascade: `ST_BASE` goes to `ST_CASC` when cascaded mode is selected.
- base-to-mode: `ST_BASE` goes to `ST_MODE` in single mode when the mode word is expected.
- base-to-run: `ST_BASE` goes to `ST_RUN` in single mode when no mode word follows.
- cascade-to-mode: `ST_CASC` goes to `ST_MODE` when the mode word is expected.
- cascade-to-run: `ST_CASC` goes to `ST_RUN` when no mode word follows.
- mode-to-run: `ST_MODE` goes to `ST_RUN` on the mode word.

Odd-address writes in `ST_UNINIT` and in `ST_RUN` do not change the state.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, `int_out` and `vector_valid` are low. In both units, a read of the odd address returns 0xFF (all lines masked) and a read of the even address returns 0x00 (nothing in service).
- R2: An even-address write with bit 4 set starts initialization. It clears the unit's requests, in-service bits and cascade word, and it records bit 1 (1 = single unit, no cascade word) and bit 0 (1 = mode word follows). The next odd-address words are taken in order: the base word first, whose bits 7:3 form the vector base; then the cascade word, only when bit 1 was 0; then the mode word, only when bit 0 was 1. When the last word is taken, the mask becomes 0x00.
- R3: While initialization is in progress, odd-address writes are taken as initialization words and never as the mask, and a read of the odd address returns 0xFF.
- R4: After initialization, an odd-address write sets the mask (bit n masks line n), and an odd-address read returns it. A rising edge on a masked line is not recorded and does not become pending when the line is later unmasked.
- R5: A rising edge on an unmasked line sets its request. `int_out` is high while some pending line has a lower index (a higher priority) than every line in service of the primary unit.
- R6: A one-cycle `inta` pulse while `int_out` is high makes `vector_valid` high for exactly the next cycle, with `vector` equal to the base plus the index of the highest-priority pending line. That line moves from pending to in service. An `inta` pulse while `int_out` is low leaves `vector_valid` low and changes no state.
- R7: On the primary, bit k of the cascade word makes input k follow the secondary's interrupt output in place of `irq_in[k]`. When such a line is acknowledged, the secondary whose cascade word equals k supplies the vector from its own highest-priority pending line.
- R8: Writing 0x20 to the even address of an initialized unit clears its lowest-numbered in-service bit. Other even-address writes with bit 4 clear have no effect.
- R9: A line in service blocks new interrupts from itself and from higher-numbered lines until its in-service bit clears. A lower-numbered line still interrupts, which nests the interrupts.
- R10: A secondary-line interrupt leaves the cascade line in service on the primary. Further secondary interrupts stay blocked until end-of-interrupt has also been written to the primary.
- R11: The even-address read returns the unit's in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| cs | input | 1 | Unit select: 0 primary, 1 secondary |
| addr | input | 1 | Register address bit: 0 even, 1 odd |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data: odd address gives the mask, even address gives in-service bits |
| irq_in | input | 16 | Interrupt lines; 7:0 go to the primary, 15:8 to the secondary |
| inta | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector_valid | output | 1 | One-cycle strobe that qualifies `vector` |
| vector | output | 8 | Vector of the acknowledged line |

## Verification
An in-service bit that is stuck shows up as a missing `int_out` on the very next edge of any line at or below that priority, and the even-address read also exposes it. A request lost or duplicated in the edge latch shows up on the following acknowledge, either as a wrong vector or as an `int_out` that stays high after all expected vectors have been drained. A fault in the init sequencer, such as a word counted against the wrong step, moves the vector base or leaves the mask at 0xFF. Either is visible within a cycle of the first mask read or the first acknowledge. Cascade routing errors show as a secondary vector replaced by a primary vector, or as the primary failing to block a second secondary line before its end-of-interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_RUN
    } init_state_t;

    localparam logic [7:0] EOI_NONSPEC = 8'h20;
    localparam int         START_BIT   = 4;
    localparam int         SINGLE_BIT  = 1;
    localparam int         MODE_BIT    = 0;

endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int  N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter int  LINES = 8,
    localparam int IW    = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [7:0]       wr_data,
    input  logic [LINES-1:0] irq_lines,
    input  logic             ack_req,
    output logic             int_o,
    output logic [7-IW:0]    base_o,
    output logic [IW-1:0]    idx_o,
    output logic [LINES-1:0] casc_o,
    output logic [7:0]       rd_data
);

    init_state_t      state, nxt;
    logic             need_mode, single;
    logic [7-IW:0]    base;
    logic [LINES-1:0] casc, mask, irr, isr, prev;
    logic [LINES-1:0] rise, pend, take_vec, eoi_vec;
    logic             start, odd_wr, eoi;
    logic             pend_found, isr_found;
    logic [IW-1:0]    pend_idx, isr_idx;

    assign start  = wr_en && !addr && wr_data[START_BIT];
    assign odd_wr = wr_en && addr;
    assign eoi    = wr_en && !addr && (wr_data == EOI_NONSPEC) && (state == ST_RUN);
    assign rise   = irq_lines & ~prev;
    assign pend   = irr & ~mask;

    irqc_prio #(.N(LINES)) u_pend_prio (.req(pend), .found(pend_found), .idx(pend_idx));
    irqc_prio #(.N(LINES)) u_isr_prio  (.req(isr),  .found(isr_found),  .idx(isr_idx));

    // Next-state logic of the init sequencer
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_BASE;
        end else if (odd_wr) begin
            unique case (state)
                ST_BASE:   nxt = single ? (need_mode ? ST_MODE : ST_RUN) : ST_CASC;
                ST_CASC:   nxt = need_mode ? ST_MODE : ST_RUN;
                ST_MODE:   nxt = ST_RUN;
                ST_UNINIT: nxt = ST_UNINIT;
                ST_RUN:    nxt = ST_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNINIT;
        else        state <= nxt;
    end

    assign int_o    = pend_found && (!isr_found || (pend_idx < isr_idx));
    assign take_vec = (ack_req && int_o) ? (LINES'(1) << pend_idx) : '0;
    assign eoi_vec  = (eoi && isr_found) ? (LINES'(1) << isr_idx) : '0;

    // Configuration and interrupt bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_mode <= 1'b0;
            single    <= 1'b0;
            base      <= '0;
            casc      <= '0;
            mask      <= '1;
            irr       <= '0;
            isr       <= '0;
            prev      <= '0;
        end else begin
            prev <= irq_lines;
            if (start) begin
                need_mode <= wr_data[MODE_BIT];
                single    <= wr_data[SINGLE_BIT];
                casc      <= '0;
                mask      <= '1;
                irr       <= '0;
                isr       <= '0;
            end else begin
                if (odd_wr && state == ST_BASE) base <= wr_data[7:IW];
                if (odd_wr && state == ST_CASC) casc <= wr_data[LINES-1:0];
                if (state != ST_RUN && nxt == ST_RUN) mask <= '0;
                else if (odd_wr && state == ST_RUN)   mask <= wr_data[LINES-1:0];
                irr <= (irr & ~take_vec) | (rise & ~mask & {LINES{state == ST_RUN}});
                isr <= (isr | take_vec) & ~eoi_vec;
            end
        end
    end

    assign base_o  = base;
    assign idx_o   = pend_idx;
    assign casc_o  = casc;
    assign rd_data = addr ? 8'(mask) : 8'(isr);

    a_r3_masked_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (mask == '1));

    a_r4_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((irr & ~$past(irr) & $past(mask)) == '0));

    a_r6_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && int_o && !wr_en) |=> ($countones(isr) == $past($countones(isr)) + 1));

    a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (isr != '0) && !(ack_req && int_o)) |=> ($countones(isr) == $past($countones(isr)) - 1));

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
    parameter int  LINES = 8,
    localparam int IW    = $clog2(LINES),
    localparam int TOTAL = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             cs,
    input  logic             addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [TOTAL-1:0] irq_in,
    input  logic             inta,
    output logic             int_out,
    output logic             vector_valid,
    output logic [7:0]       vector
);

    logic [LINES-1:0] prim_in, prim_casc, sec_casc;
    logic             prim_int, sec_int, sec_hit, sec_ack;
    logic [7-IW:0]    prim_base, sec_base;
    logic [IW-1:0]    prim_idx, sec_idx;
    logic [7:0]       prim_rd, sec_rd;

    for (genvar k = 0; k < LINES; k++) begin : g_prim_in
        assign prim_in[k] = prim_casc[k] ? sec_int : irq_in[k];
    end

    assign sec_hit = prim_casc[prim_idx] && (sec_casc == LINES'(prim_idx));
    assign sec_ack = inta && prim_int && sec_hit;

    irqc_unit #(.LINES(LINES)) u_prim (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !cs), .addr(addr), .wr_data(wr_data),
        .irq_lines(prim_in), .ack_req(inta), .int_o(prim_int), .base_o(prim_base),
        .idx_o(prim_idx), .casc_o(prim_casc), .rd_data(prim_rd)
    );

    irqc_unit #(.LINES(LINES)) u_sec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && cs), .addr(addr), .wr_data(wr_data),
        .irq_lines(irq_in[TOTAL-1:LINES]), .ack_req(sec_ack), .int_o(sec_int), .base_o(sec_base),
        .idx_o(sec_idx), .casc_o(sec_casc), .rd_data(sec_rd)
    );

    assign int_out = prim_int;
    assign rd_data = cs ? sec_rd : prim_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vector_valid <= 1'b0;
            vector       <= '0;
        end else begin
            vector_valid <= inta && prim_int;
            if (inta && prim_int) vector <= sec_hit ? {sec_base, sec_idx} : {prim_base, prim_idx};
        end
    end

    a_r6_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |-> $past(inta));

    a_r7_cascade_vector_source: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ack) |=> (vector[IW-1:0] == $past(sec_idx)));

endmodule

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, cs = 1'b0, addr = 1'b0, inta = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] irq_in = '0;
    logic [7:0]  rd_data, vector;
    logic        int_out, vector_valid;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    irq_cascade_ctrl u_irq_cascade_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cs(cs), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_in(irq_in), .inta(inta), .int_out(int_out),
        .vector_valid(vector_valid), .vector(vector)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic u, input logic a, input logic [7:0] d);
        @(negedge clk);
        cs = u; addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic u, input logic a, output logic [7:0] d);
        @(negedge clk);
        cs = u; addr = a;
        #1 d = rd_data;
    endtask

    task automatic pulse(input logic [15:0] lines);
        @(negedge clk);
        irq_in = lines;
        repeat (2) @(negedge clk);
        irq_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack(output logic v, output logic [7:0] vec);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vector_valid; vec = vector;
        @(negedge clk);
        chk("R6 valid one cycle", 16'(vector_valid), 16'h0);
    endtask

    task automatic init_std;
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    endtask

    // Expected next vector for the standard setup: secondary on primary line 2
    function automatic logic [7:0] exp_vec(input logic [15:0] p);
        logic [7:0] prim = p[7:0];
        if (p[15:8] != 0) prim[2] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (prim[i]) begin
                if (i != 2) return 8'h20 + 8'(i);
                for (int j = 8; j < 16; j++) if (p[j]) return 8'h20 + 8'(j);
            end
        end
        return 8'hxx;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d, vec;
        logic        v;
        logic [15:0] pend;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 int_out", 16'(int_out), 16'h0);
        chk("R1 vector_valid", 16'(vector_valid), 16'h0);
        rd(0, 1, d); chk("R1 primary mask", 16'(d), 16'hFF);
        rd(1, 1, d); chk("R1 secondary mask", 16'(d), 16'hFF);
        rd(0, 0, d); chk("R1 primary in-service", 16'(d), 16'h00);

        // R2/R3 init words, mask reads 0xFF mid-sequence
        wr(0, 0, 8'h11); wr(0, 1, 8'h20);
        rd(0, 1, d); chk("R3 mask during init", 16'(d), 16'hFF);
        wr(0, 1, 8'h04);
        rd(0, 1, d); chk("R3 mask before mode word", 16'(d), 16'hFF);
        wr(0, 1, 8'h01);
        rd(0, 1, d); chk("R2 mask after init", 16'(d), 16'h00);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);

        // R5/R6 simple primary line
        pulse(16'h0020);
        chk("R5 int on line 5", 16'(int_out), 16'h1);
        ack(v, vec);
        chk("R6 valid", 16'(v), 16'h1);
        chk("R6 vector line 5", 16'(vec), 16'h25);
        rd(0, 0, d); chk("R11 in-service bit5", 16'(d), 16'h20);
        chk("R9 int low after ack", 16'(int_out), 16'h0);

        // R9 blocking and nesting
        pulse(16'h0040);
        chk("R9 line 6 blocked", 16'(int_out), 16'h0);
        pulse(16'h0002);
        chk("R9 line 1 nests", 16'(int_out), 16'h1);
        ack(v, vec); chk("R9 nested vector", 16'(vec), 16'h21);
        wr(0, 0, 8'h20);
        rd(0, 0, d); chk("R8 eoi clears lowest", 16'(d), 16'h20);
        chk("R9 line 6 still blocked", 16'(int_out), 16'h0);
        wr(0, 0, 8'h08);
        rd(0, 0, d); chk("R8 other command ignored", 16'(d), 16'h20);
        wr(0, 0, 8'h20);
        @(negedge clk);
        chk("R9 line 6 released", 16'(int_out), 16'h1);
        ack(v, vec); chk("R6 vector line 6", 16'(vec), 16'h26);
        wr(0, 0, 8'h20);

        // R6 acknowledge with nothing pending
        ack(v, vec); chk("R6 no valid when idle", 16'(v), 16'h0);

        // R4 mask
        wr(0, 1, 8'h08);
        rd(0, 1, d); chk("R4 mask readback", 16'(d), 16'h08);
        pulse(16'h0008);
        chk("R4 masked line silent", 16'(int_out), 16'h0);
        wr(0, 1, 8'h00);
        repeat (2) @(negedge clk);
        chk("R4 masked edge not kept", 16'(int_out), 16'h0);

        // R7/R10 cascade
        pulse(16'h0400);
        chk("R7 cascade int", 16'(int_out), 16'h1);
        ack(v, vec); chk("R7 secondary vector", 16'(vec), 16'h2A);
        rd(0, 0, d); chk("R10 primary cascade in service", 16'(d), 16'h04);
        rd(1, 0, d); chk("R7 secondary in service", 16'(d), 16'h04);
        wr(1, 0, 8'h20);
        pulse(16'h1000);
        chk("R10 blocked until primary eoi", 16'(int_out), 16'h0);
        wr(0, 0, 8'h20);
        repeat (2) @(negedge clk);
        chk("R10 released", 16'(int_out), 16'h1);
        ack(v, vec); chk("R7 secondary vector line 12", 16'(vec), 16'h2C);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);

        // R2 single mode without mode word; line 2 is an ordinary input then
        wr(0, 0, 8'h12); wr(0, 1, 8'h40);
        rd(0, 1, d); chk("R2 short sequence unmasks", 16'(d), 16'h00);
        pulse(16'h0004);
        ack(v, vec); chk("R2 new base, R7 cascade cleared", 16'(vec), 16'h42);
        wr(0, 0, 8'h20);
        init_std();

        // Random bursts against the model
        for (int r = 0; r < 40; r++) begin
            pend = 16'($urandom) & 16'hFFFB;
            if (pend == 0) pend = 16'h0001;
            pulse(pend);
            while (pend != 0) begin
                repeat (3) @(negedge clk);
                chk("R5 random int", 16'(int_out), 16'h1);
                ack(v, vec);
                chk("R6 random valid", 16'(v), 16'h1);
                chk("R7 random vector", 16'(vec), 16'(exp_vec(pend)));
                if (vec >= 8'h28) wr(1, 0, 8'h20);
                wr(0, 0, 8'h20);
                pend[exp_vec(pend) - 8'h20] = 1'b0;
            end
            repeat (3) @(negedge clk);
            chk("R5 random drained", 16'(int_out), 16'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule